// File: doc/BRIEF.md
# Page-Size Configuration Command Unit

This block is the device-side command recogniser for a serial flash that lets the host set the page size once. While the chip select is low, it samples the serial data line on each rising edge of the serial clock. It checks the incoming bytes against a fixed four-byte opcode. When a frame that matched exactly is closed by chip select going high, the block runs a self-timed program cycle of fixed length and then sets a nonvolatile configuration bit.

A status byte on a parallel port shows a ready flag and the configuration bit. The effective page size is 528 bytes by default and 512 bytes once the bit is set. The new size does not apply at once. It takes effect only after the next power-on reset, which this block models as an input. The nonvolatile bit keeps its value through that reset. If the reset arrives during the program cycle, the cycle is abandoned and the bit stays clear.

The serial pins are brought into the system clock domain by two-flop synchronisers. The serial clock must be slow enough that each of its levels lasts several system clocks.

Top module: `pagecfg_cmd_unit`

## Requirements
- R1: After a power-on reset with the configuration bit clear, busy is 0, the status byte is 0x80 and the page size is 528.
- R2: A program cycle starts when a chip-select-low frame holds exactly the bytes 0x3D, 0x2A, 0x80, 0xA6 in that order, each shifted MSB first on rising SCK edges, and chip select then rises.
- R3: The program cycle holds busy high for exactly PROG_CYCLES system clocks. Status bit 7 is 1 when the unit is ready and 0 while it is busy.
- R4: Status bit 0 (the configuration bit) becomes 1 in the cycle in which busy falls. The page size stays 528 until the next power-on reset.
- R5: A power-on reset with the configuration bit set gives page size 512 and status 0x81.
- R6: A four-byte frame with any wrong byte, or with the right bytes in another order, does not start a program cycle.
- R7: A frame of three bytes or of five bytes does not start a program cycle.
- R8: A frame whose chip select rises partway through a byte does not start a program cycle.
- R9: A power-on reset during a program cycle clears busy and leaves bit 0 at 0 and the page size at 528. Issuing the command again afterwards completes normally.
- R10: Once bit 0 is set, a further valid command does not start busy, and both bit 0 and the page size are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | Power-on reset, active low, synchronous |
| sck | input | 1 | Serial clock from the host |
| csN | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| busy | output | 1 | High while the program cycle runs |
| statusByte | output | 8 | Bit 7 ready, bit 0 configuration bit, other bits 0 |
| pageSize | output | 10 | Effective page size in bytes (528 or 512) |

## Verification
Chip select passes through a synchroniser and an edge register, so busy rises on the third system clock edge after csN rises. It then stays high for exactly PROG_CYCLES cycles, and the configuration bit sets on the edge where busy falls. The page size changes only at the clock edges taken while porN is low. The bench does not sample busy at one fixed instant. After each frame it watches a window on falling clock edges that covers the synchroniser latency plus the whole cycle. In that window it counts the busy cycles and checks the ready bit on every cycle. Status and page size are read only after that window closes, or a few cycles after porN is released.

// File: rtl/pagecfg_cmd_pkg.sv
package pagecfg_cmd_pkg;
  localparam int OPC_LEN = 4;

  typedef struct packed {
    logic timerLoad;
    logic timerTick;
    logic nvCommit;
  } ctrlStrobe_t;

  typedef enum logic {ST_IDLE, ST_PROG} ctrlState_t;

  function automatic logic [7:0] opcodeAt(input logic [2:0] idx);
    case (idx)
      3'd0:    return 8'h3D;
      3'd1:    return 8'h2A;
      3'd2:    return 8'h80;
      3'd3:    return 8'hA6;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/pagecfg_cmd_ctrl.sv
module pagecfg_cmd_ctrl
  import pagecfg_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        porN,
  input  logic        csRise,
  input  logic        frameGood,
  input  logic        nvBit,
  input  logic        timerDone,
  output ctrlStrobe_t strobe,
  output logic        busy
);
  ctrlState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!porN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (csRise && frameGood && !nvBit) begin
          strobe.timerLoad = 1'b1;
          stateNext        = ST_PROG;
        end
      end
      ST_PROG: begin
        if (timerDone) begin
          strobe.nvCommit = 1'b1;
          stateNext       = ST_IDLE;
        end else begin
          strobe.timerTick = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state == ST_PROG);
endmodule

// File: rtl/pagecfg_cmd_datapath.sv
module pagecfg_cmd_datapath
  import pagecfg_cmd_pkg::*;
#(
  parameter int PROG_CYCLES = 2000
) (
  input  logic        clk,
  input  logic        porN,
  input  logic        sck,
  input  logic        csN,
  input  logic        si,
  input  ctrlStrobe_t strobe,
  output logic        csRise,
  output logic        frameGood,
  output logic        timerDone,
  output logic        nvBit,
  output logic        pageBin
);
  localparam int TMR_W = $clog2(PROG_CYCLES + 1);

  logic [1:0] sckSync, csSync, siSync;
  logic       sckPrev, csPrev;
  logic       sckRise, csLow, siBit;

  always_ff @(posedge clk) begin
    if (!porN) begin
      sckSync <= 2'b00;
      csSync  <= 2'b11;
      siSync  <= 2'b00;
      sckPrev <= 1'b0;
      csPrev  <= 1'b1;
    end else begin
      sckSync <= {sckSync[0], sck};
      csSync  <= {csSync[0], csN};
      siSync  <= {siSync[0], si};
      sckPrev <= sckSync[1];
      csPrev  <= csSync[1];
    end
  end

  assign sckRise = sckSync[1] & ~sckPrev;
  assign csLow   = ~csSync[1];
  assign csRise  = csSync[1] & ~csPrev;
  assign siBit   = siSync[1];

  // frame tracking: bit position, byte count (saturating) and match flag
  logic [2:0] bitCnt, byteCnt;
  logic [6:0] shiftReg;
  logic       matchOk;
  logic [7:0] byteNow;

  assign byteNow = {shiftReg, siBit};

  always_ff @(posedge clk) begin
    if (!porN || !csLow) begin
      bitCnt   <= '0;
      byteCnt  <= '0;
      matchOk  <= 1'b1;
      shiftReg <= '0;
    end else if (sckRise) begin
      shiftReg <= byteNow[6:0];
      bitCnt   <= bitCnt + 3'd1;
      if (bitCnt == 3'd7) begin
        if (byteCnt >= 3'(OPC_LEN) || byteNow != opcodeAt(byteCnt))
          matchOk <= 1'b0;
        if (byteCnt != 3'd7) byteCnt <= byteCnt + 3'd1;
      end
    end
  end

  assign frameGood = matchOk && (byteCnt == 3'(OPC_LEN)) && (bitCnt == 3'd0);

  // program-cycle timer
  logic [TMR_W-1:0] tmrCnt;

  always_ff @(posedge clk) begin
    if (!porN)                                tmrCnt <= '0;
    else if (strobe.timerLoad)                tmrCnt <= TMR_W'(PROG_CYCLES - 1);
    else if (strobe.timerTick && tmrCnt != 0) tmrCnt <= tmrCnt - 1'b1;
  end

  assign timerDone = (tmrCnt == '0);

  // nonvolatile bit: no reset, survives power-on reset
  logic nvReg = 1'b0;
  always_ff @(posedge clk) begin
    if (strobe.nvCommit) nvReg <= 1'b1;
  end
  assign nvBit = nvReg;

  // effective page size latched only during power-on reset
  always_ff @(posedge clk) begin
    if (!porN) pageBin <= nvReg;
  end
endmodule

// File: rtl/pagecfg_cmd_unit.sv
module pagecfg_cmd_unit
  import pagecfg_cmd_pkg::*;
#(
  parameter int PROG_CYCLES = 2000,
  parameter int PAGE_STD    = 528,
  parameter int PAGE_BIN    = 512,
  localparam int PAGE_W     = $clog2(PAGE_STD + 1)
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              sck,
  input  logic              csN,
  input  logic              si,
  output logic              busy,
  output logic [7:0]        statusByte,
  output logic [PAGE_W-1:0] pageSize
);
  ctrlStrobe_t strobe;
  logic csRise, frameGood, timerDone, nvBit, pageBin;

  pagecfg_cmd_ctrl ctrlI (
    .clk(clk), .porN(porN), .csRise(csRise), .frameGood(frameGood),
    .nvBit(nvBit), .timerDone(timerDone), .strobe(strobe), .busy(busy)
  );

  pagecfg_cmd_datapath #(.PROG_CYCLES(PROG_CYCLES)) dpI (
    .clk(clk), .porN(porN), .sck(sck), .csN(csN), .si(si), .strobe(strobe),
    .csRise(csRise), .frameGood(frameGood), .timerDone(timerDone),
    .nvBit(nvBit), .pageBin(pageBin)
  );

  assign statusByte = {~busy, 6'b000000, nvBit};
  assign pageSize   = pageBin ? PAGE_W'(PAGE_BIN) : PAGE_W'(PAGE_STD);
endmodule

// File: rtl/pagecfg_cmd_chk.sv
module pagecfg_cmd_chk #(
  parameter int PAGE_STD = 528,
  parameter int PAGE_BIN = 512,
  parameter int PAGE_W   = 10
) (
  input logic              clk,
  input logic              porN,
  input logic              busy,
  input logic [7:0]        statusByte,
  input logic [PAGE_W-1:0] pageSize
);
  // R3
  ready_flag_chk: assert property (@(posedge clk) disable iff (!porN)
    busy |-> !statusByte[7]);

  // R10
  nv_sticky_chk: assert property (@(posedge clk) disable iff (!porN)
    $past(statusByte[0]) |-> statusByte[0]);

  // R4
  nv_at_end_chk: assert property (@(posedge clk) disable iff (!porN)
    $rose(statusByte[0]) |-> $fell(busy));

  // R4
  page_hold_chk: assert property (@(posedge clk) disable iff (!porN)
    $past(porN) |-> $stable(pageSize));

  // R5
  page_legal_chk: assert property (@(posedge clk) disable iff (!porN)
    (pageSize == PAGE_W'(PAGE_STD)) || (pageSize == PAGE_W'(PAGE_BIN)));

  // R10
  no_reprog_chk: assert property (@(posedge clk) disable iff (!porN)
    $rose(busy) |-> !statusByte[0]);
endmodule

bind pagecfg_cmd_unit pagecfg_cmd_chk #(
  .PAGE_STD(PAGE_STD), .PAGE_BIN(PAGE_BIN), .PAGE_W(PAGE_W)
) chkI (
  .clk(clk), .porN(porN), .busy(busy), .statusByte(statusByte), .pageSize(pageSize)
);

// File: tb/tb_pagecfg_cmd_unit.sv
module tb_pagecfg_cmd_unit;
  localparam int P = 40;

  logic clk = 1'b0;
  logic porN = 1'b0, sck = 1'b0, csN = 1'b1, si = 1'b0;
  logic busy;
  logic [7:0] statusByte;
  logic [9:0] pageSize;

  int nChk = 0, nFail = 0;

  always #2.5 clk = ~clk;

  pagecfg_cmd_unit #(.PROG_CYCLES(P)) dut (
    .clk(clk), .porN(porN), .sck(sck), .csN(csN), .si(si),
    .busy(busy), .statusByte(statusByte), .pageSize(pageSize)
  );

  typedef struct packed {
    logic [2:0]  nBytes;
    logic [2:0]  extraBits;
    logic [39:0] bytes;     // first byte in bits 39:32
    logic [3:0]  req;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{3'd4, 3'd0, 40'h3D2A80A700, 4'd6},
    '{3'd4, 3'd0, 40'h2A3D80A600, 4'd6},
    '{3'd3, 3'd0, 40'h3D2A800000, 4'd7},
    '{3'd5, 3'd0, 40'h3D2A80A600, 4'd7},
    '{3'd4, 3'd3, 40'h3D2A80A600, 4'd8},
    '{3'd3, 3'd5, 40'h3D2A80A600, 4'd8}
  };

  localparam logic [39:0] GOOD = 40'h3D2A80A600;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendFrame(input int nBytes, input int extra, input logic [39:0] b);
    csN = 1'b0;
    #20;
    for (int i = 0; i < nBytes * 8 + extra; i++) begin
      si = b[39 - i];
      #20 sck = 1'b1;
      #20 sck = 1'b0;
    end
    #20 csN = 1'b1;
  endtask

  int bad7;
  task automatic watchBusy(output int len);
    len = 0;
    repeat (P + 30) begin
      @(negedge clk);
      if (busy) len++;
      if (statusByte[7] !== !busy) bad7++;
    end
  endtask

  task automatic powerCycle();
    @(negedge clk) porN = 1'b0;
    repeat (3) @(negedge clk);
    porN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #200000;
    nFail++; nChk++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    int len;
    bad7 = 0;
    repeat (4) @(negedge clk);
    porN = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 1'b0, "R1", busy, 0);
    check(statusByte == 8'h80, "R1", statusByte, 8'h80);
    check(pageSize == 10'd528, "R1", pageSize, 528);

    // bad frames from the table: none starts a cycle (R6 R7 R8)
    foreach (TBL[k]) begin
      sendFrame(TBL[k].nBytes, TBL[k].extraBits, TBL[k].bytes);
      watchBusy(len);
      check(len == 0, $sformatf("R%0d", TBL[k].req), len, 0);
      check(statusByte == 8'h80, $sformatf("R%0d", TBL[k].req), statusByte, 8'h80);
    end

    // R9: abort by power-on reset mid cycle
    sendFrame(4, 0, GOOD);
    repeat (10) @(negedge clk);
    check(busy == 1'b1, "R2", busy, 1);
    powerCycle();
    check(busy == 1'b0, "R9", busy, 0);
    check(statusByte == 8'h80, "R9", statusByte, 8'h80);
    check(pageSize == 10'd528, "R9", pageSize, 528);

    // R2 R3 R4: full cycle after reissue
    sendFrame(4, 0, GOOD);
    watchBusy(len);
    check(len == P, "R3", len, P);
    check(bad7 == 0, "R3", bad7, 0);
    check(statusByte == 8'h81, "R4", statusByte, 8'h81);
    check(pageSize == 10'd528, "R4", pageSize, 528);

    // R5: applies after power cycle
    powerCycle();
    check(pageSize == 10'd512, "R5", pageSize, 512);
    check(statusByte == 8'h81, "R5", statusByte, 8'h81);

    // R10: one-time programmable
    sendFrame(4, 0, GOOD);
    watchBusy(len);
    check(len == 0, "R10", len, 0);
    check(statusByte == 8'h81, "R10", statusByte, 8'h81);
    powerCycle();
    check(pageSize == 10'd512, "R10", pageSize, 512);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule